// File: doc/BRIEF.md
# Mode-Configurable Registered Bus Transceiver

This block is a bidirectional data path, `WIDTH` channels wide, between a single-ended side A and a differential bus side B. The bus pair of each channel is modelled as one logic bit plus a drive enable. A separate per-bit flag marks a channel whose bus input is open or undriven. Each direction has its own two-bit mode input and its own strobe input. The mode picks the element in that direction's path: a straight buffer, a flip-flop loaded on the strobe's rising edge, or a latch that is transparent while the strobe is high.

The two strobes are sampled by the block clock. A flip-flop load happens on the first clock edge at which the strobe is seen high after being low. A latch stores on every clock edge while its strobe is high, and its output follows the input with no delay while the strobe is high. Each side has its own output enable. The bus receiver has an active-low enable.

A side-A loopback control feeds the A-to-B element output into the B-to-A element in place of the received bus data. Setting all four mode bits high selects an echo mode. In that mode the received bus data is held in the B-to-A latch and driven back out through the A-to-B latch. Storage in both directions keeps working while the outputs are disabled.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: A direction's mode code decodes as 00 buffer, 01 flip-flop, 10 latch, 11 echo. Code 11 takes effect only when both directions carry 11; code 11 in one direction alone behaves as a latch.
- R2: In buffer mode the direction's output equals its input in the same cycle, with no clock edge needed.
- R3: In flip-flop mode the stored value loads from the input only on a clock edge where the strobe is high and was low at the previous edge. At all other edges it holds.
- R4: In latch mode the output follows the input while the strobe is high. The last value present at a clock edge with the strobe high is held while the strobe is low.
- R5: In echo mode (all four mode bits 1), the received bus data is stored in the B-to-A latch. The A-to-B latch takes that stored value as its input and drives it onto the bus.
- R6: While the loopback control is high, the B-to-A element takes its input from the A-to-B element output. Received bus data has no effect.
- R7: With the A-side enable low, `a_out` is all zeros and `a_oe` is 0. With the B-side enable low, `b_out` is all zeros and `b_oe` is 0.
- R8: Both storage elements load and hold while their outputs are disabled. Enabling an output shows the stored value at once.
- R9: With `rx_en_n` high, the receiver delivers all zeros.
- R10: A channel whose `b_open` bit is 1 receives logic 0.
- R11: Reset clears both storage elements to zero.
- R12: During loopback the bus driver may stay enabled, and `b_out` then carries the transmitted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples strobes and stores data |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | Side-A data input |
| a_out | output | WIDTH | Side-A data output, zero when disabled |
| a_oe | output | 1 | Side-A drive enable |
| b_in | input | WIDTH | Received bus bit per channel |
| b_open | input | WIDTH | Per-channel flag: bus input open or undriven |
| b_out | output | WIDTH | Bus transmit bit per channel, zero when disabled |
| b_oe | output | 1 | Bus drive enable |
| ab_mode | input | 2 | A-to-B mode code |
| ba_mode | input | 2 | B-to-A mode code |
| ab_strobe | input | 1 | A-to-B clock/latch enable |
| ba_strobe | input | 1 | B-to-A clock/latch enable |
| a_en | input | 1 | Side-A output enable, active high |
| b_en | input | 1 | Bus output enable, active high |
| rx_en_n | input | 1 | Bus receiver enable, active low |
| lpbk | input | 1 | Side-A loopback control |

## Verification
A stored value that is wrong or was loaded at the wrong time stays hidden while its output enable is low. It shows on the data port in the same cycle the enable rises. A flip-flop that loads on a level instead of an edge shows one clock after a second input change while the strobe stays high. A latch that fails to hold shows as soon as the strobe drops and the input moves. A fault in the echo or loopback routing shows one clock after the upstream element stores, because the downstream element reads that stored value.

// File: rtl/xcvr_pkg.sv
// Shared types for the registered bus transceiver.
package xcvr_pkg;
    // Per-direction path element, encoded as the two mode input bits.
    typedef enum logic [1:0] {
        XM_BUF  = 2'b00,
        XM_FF   = 2'b01,
        XM_LAT  = 2'b10,
        XM_ECHO = 2'b11
    } xfer_mode_e;
endpackage

// File: rtl/xfer_stage.sv
// One direction's path element: buffer, edge-loaded flip-flop or
// transparent-high latch, selected by mode. XM_ECHO acts as a latch here;
// the top decides where its data comes from. Assumes strobe is synchronous
// to clk; a rising strobe is found by comparing with its value at the last edge.
module xfer_stage
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfer_mode_e       mode,
    input  logic             strobe,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] held
);
    logic strobe_q;
    logic is_lat;
    logic rise;

    assign is_lat = (mode == XM_LAT) || (mode == XM_ECHO);
    assign rise   = strobe && !strobe_q;

    // Remember the strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Storage: load on strobe rise (flip-flop) or while strobe high (latch).
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if ((mode == XM_FF && rise) || (is_lat && strobe))
            held <= d;
    end

    // Output select: direct input, stored value, or transparent latch.
    always_comb begin
        case (mode)
            XM_BUF:  q = d;
            XM_FF:   q = held;
            default: q = strobe ? d : held;
        endcase
    end

    // R3: flip-flop holds unless the strobe rose
    p_ff_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_FF && !rise) |=> $stable(held));
    // R3: flip-flop loads the input present at the rising strobe
    p_ff_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_FF && rise) |=> held == $past(d));
    // R4: latch holds while the strobe is low
    p_lat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lat && !strobe) |=> $stable(held));
    // R4: latch is transparent while the strobe is high
    p_lat_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lat && strobe) |-> q == d);
    // R2: buffer passes input straight through
    p_buf_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_BUF) |-> q == d);
endmodule

// File: rtl/bus_rx_front.sv
// Bus receiver front end: per channel, delivers the received bit only when
// the receiver is enabled (active low) and the channel is not flagged open.
// An open channel or a disabled receiver yields logic 0 (fail-safe).
module bus_rx_front #(
    parameter int WIDTH = 8
) (
    input  logic             rx_en_n,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] b_open,
    output logic [WIDTH-1:0] rx_bits
);
    // One fail-safe gate per channel.
    for (genvar i = 0; i < WIDTH; i++) begin : g_ch
        assign rx_bits[i] = !rx_en_n && !b_open[i] && b_in[i];
    end
endmodule

// File: rtl/bidir_reg_xcvr.sv
// Top of the registered bus transceiver. Decodes the two mode codes,
// routes data for normal, side-A loopback and bus echo operation, and gates
// both sides with their output enables. Assumes all control inputs are
// synchronous to clk. In echo mode the A-to-B element reads the B-to-A
// stored value, so the echo is delayed by one B-to-A store.
module bidir_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] b_open,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic [1:0]       ab_mode,
    input  logic [1:0]       ba_mode,
    input  logic             ab_strobe,
    input  logic             ba_strobe,
    input  logic             a_en,
    input  logic             b_en,
    input  logic             rx_en_n,
    input  logic             lpbk
);
    xfer_mode_e       ab_m, ba_m;
    logic             bus_echo;
    logic [WIDTH-1:0] rx_bits;
    logic [WIDTH-1:0] ab_d, ab_q, ab_held;
    logic [WIDTH-1:0] ba_d, ba_q, ba_held;

    assign ab_m     = xfer_mode_e'(ab_mode);
    assign ba_m     = xfer_mode_e'(ba_mode);
    assign bus_echo = (ab_m == XM_ECHO) && (ba_m == XM_ECHO);

    // Data sources: loopback takes priority over echo, so no data loop forms.
    always_comb begin
        ab_d = (bus_echo && !lpbk) ? ba_held : a_in;
        ba_d = lpbk ? ab_q : rx_bits;
    end

    bus_rx_front #(.WIDTH(WIDTH)) u_rx (
        .rx_en_n (rx_en_n),
        .b_in    (b_in),
        .b_open  (b_open),
        .rx_bits (rx_bits)
    );

    xfer_stage #(.WIDTH(WIDTH)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (ab_m),
        .strobe (ab_strobe),
        .d      (ab_d),
        .q      (ab_q),
        .held   (ab_held)
    );

    xfer_stage #(.WIDTH(WIDTH)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (ba_m),
        .strobe (ba_strobe),
        .d      (ba_d),
        .q      (ba_q),
        .held   (ba_held)
    );

    // Output gating: a disabled side drives zeros with its enable low.
    always_comb begin
        a_oe  = a_en;
        b_oe  = b_en;
        a_out = a_en ? ba_q : '0;
        b_out = b_en ? ab_q : '0;
    end

    // R7: disabled side A is quiet
    p_a_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |-> (a_out == '0 && !a_oe));
    // R7: disabled bus side is quiet
    p_b_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |-> (b_out == '0 && !b_oe));
    // R9: receiver off gives zeros through a B-to-A buffer
    p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en_n && !lpbk && ba_m == XM_BUF) |-> a_out == '0);
    // R10: open channels read as zero through a B-to-A buffer
    p_failsafe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lpbk && ba_m == XM_BUF) |-> (a_out & b_open) == '0);
    // R5: in echo mode with the A-to-B strobe high the bus carries the B-to-A stored data
    p_echo_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_echo && !lpbk && ab_strobe && b_en) |-> b_out == ba_held);
    // R5: in echo mode with the A-to-B strobe low the bus carries the A-to-B held data
    p_echo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_echo && !ab_strobe && b_en) |-> b_out == ab_held);
endmodule

// File: tb/tb_bidir_reg_xcvr.sv
module tb_bidir_reg_xcvr;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, b_open = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic [1:0]   ab_mode = 2'b00, ba_mode = 2'b00;
    logic         ab_strobe = 1'b0, ba_strobe = 1'b0;
    logic         a_en = 1'b0, b_en = 1'b0, rx_en_n = 1'b1, lpbk = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bidir_reg_xcvr #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_open(b_open), .b_out(b_out), .b_oe(b_oe),
        .ab_mode(ab_mode), .ba_mode(ba_mode), .ab_strobe(ab_strobe),
        .ba_strobe(ba_strobe), .a_en(a_en), .b_en(b_en),
        .rx_en_n(rx_en_n), .lpbk(lpbk)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        ab_mode = 2'b01; ba_mode = 2'b01; a_en = 1'b1; b_en = 1'b1;
        a_in = 8'hFF; b_in = 8'hFF; rx_en_n = 1'b0;
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; #1;
        chk("R11 b_out after reset", b_out, 8'h00);
        chk("R11 a_out after reset", a_out, 8'h00);
    endtask

    task automatic t_buffer();
        ab_mode = 2'b00; ba_mode = 2'b00; b_en = 1'b1; a_en = 1'b1;
        rx_en_n = 1'b0; b_open = '0;
        a_in = 8'h3E; #1;
        chk("R2 A-to-B buffer", b_out, 8'h3E);
        b_in = 8'h81; #1;
        chk("R2 B-to-A buffer", a_out, 8'h81);
        step();
    endtask

    task automatic t_flop();
        ab_mode = 2'b01; b_en = 1'b1; ab_strobe = 1'b0; step();
        a_in = 8'h3C; ab_strobe = 1'b1; #1;
        chk("R3 no load before edge", b_out, 8'h00);
        step();
        chk("R3 load on strobe rise", b_out, 8'h3C);
        a_in = 8'hC3; step();
        chk("R3 hold while strobe stays high", b_out, 8'h3C);
        ab_strobe = 1'b0; step();
        ab_strobe = 1'b1; step();
        chk("R3 second rise loads", b_out, 8'hC3);
        ab_strobe = 1'b0; step();
    endtask

    task automatic t_latch();
        ab_mode = 2'b10; b_en = 1'b1; ab_strobe = 1'b0; step();
        a_in = 8'h5A; ab_strobe = 1'b1; #1;
        chk("R4 latch transparent", b_out, 8'h5A);
        a_in = 8'h96; #1;
        chk("R4 latch follows input", b_out, 8'h96);
        step();
        ab_strobe = 1'b0; a_in = 8'h11; #1;
        chk("R4 latch holds when low", b_out, 8'h96);
        step();
        chk("R4 latch still holds", b_out, 8'h96);
    endtask

    task automatic t_tristate();
        ab_mode = 2'b01; b_en = 1'b0; ab_strobe = 1'b0; step();
        a_in = 8'hE7; ab_strobe = 1'b1; step();
        chk("R7 bus quiet when disabled", b_out, 8'h00);
        chk("R7 b_oe low", {7'd0, b_oe}, 8'h00);
        b_en = 1'b1; #1;
        chk("R8 A-to-B stored while disabled", b_out, 8'hE7);
        ab_strobe = 1'b0;
        ba_mode = 2'b01; a_en = 1'b0; rx_en_n = 1'b0; b_open = '0; ba_strobe = 1'b0;
        step();
        b_in = 8'h7E; ba_strobe = 1'b1; step();
        chk("R7 side A quiet when disabled", a_out, 8'h00);
        chk("R7 a_oe low", {7'd0, a_oe}, 8'h00);
        a_en = 1'b1; #1;
        chk("R8 B-to-A stored while disabled", a_out, 8'h7E);
        ba_strobe = 1'b0; step();
    endtask

    task automatic t_rx();
        ba_mode = 2'b00; a_en = 1'b1; lpbk = 1'b0; rx_en_n = 1'b0;
        b_in = 8'hFF; b_open = 8'h0F; #1;
        chk("R10 open channels read zero", a_out, 8'hF0);
        rx_en_n = 1'b1; #1;
        chk("R9 receiver disabled", a_out, 8'h00);
        b_open = '0; step();
    endtask

    task automatic t_loop();
        ab_mode = 2'b00; ba_mode = 2'b00; lpbk = 1'b1; rx_en_n = 1'b1;
        a_en = 1'b1; b_en = 1'b1; b_in = 8'hFF; a_in = 8'h4D; #1;
        chk("R6 buffer loopback", a_out, 8'h4D);
        chk("R12 bus shows data in loopback", b_out, 8'h4D);
        rx_en_n = 1'b0; #1;
        chk("R6 bus data ignored in loopback", a_out, 8'h4D);
        ab_mode = 2'b01; ba_mode = 2'b01; ab_strobe = 1'b0; ba_strobe = 1'b0; step();
        a_in = 8'h29; ab_strobe = 1'b1; step();
        ba_strobe = 1'b1; step();
        chk("R6 flip-flop loopback", a_out, 8'h29);
        ab_strobe = 1'b0; ba_strobe = 1'b0; lpbk = 1'b0; step();
    endtask

    task automatic t_echo();
        ab_mode = 2'b11; ba_mode = 2'b11; lpbk = 1'b0; rx_en_n = 1'b0;
        b_open = '0; b_en = 1'b1; ab_strobe = 1'b0; ba_strobe = 1'b0; step();
        b_in = 8'hB2; a_in = 8'h00; ba_strobe = 1'b1; step();
        ba_strobe = 1'b0; b_in = 8'h00; ab_strobe = 1'b1; #1;
        chk("R5 echo drives stored bus data", b_out, 8'hB2);
        step();
        ab_strobe = 1'b0; step();
        chk("R5 echo holds", b_out, 8'hB2);
    endtask

    task automatic t_single11();
        ab_mode = 2'b11; ba_mode = 2'b00; b_en = 1'b1; ab_strobe = 1'b0; step();
        a_in = 8'h6C; ab_strobe = 1'b1; #1;
        chk("R1 lone 11 acts as latch on A input", b_out, 8'h6C);
        step();
        ab_strobe = 1'b0; a_in = 8'h00; #1;
        chk("R1 lone 11 latch holds", b_out, 8'h6C);
        step();
    endtask

    initial begin
        step();
        t_reset();
        t_buffer();
        t_flop();
        t_latch();
        t_tristate();
        t_rx();
        t_loop();
        t_echo();
        t_single11();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule